// File: doc/BRIEF.md
# I2C SCL Period Generator

This block produces the serial clock timing for an I2C master. A small prescaler divides the peripheral clock into an internal tick. A phase counter then counts those ticks to shape each SCL period. The period length is a fixed base of 20 ticks, plus eight ticks for each step of a coarse divider field, plus a rounding term. The rounding term stands in for line rise time, fall time and internal delay. It is computed outside the block and supplied as a plain tick count.

Each period is split into a low phase and a high phase. In the low phase the block drives SCL low. In the high phase it releases the line. The high-phase count does not begin until the line is actually seen high, so a slave that holds SCL low stretches the period. The byte controller gets a one-cycle strobe at the start of each phase. The generator stays idle while the master is disabled. A start request restarts it at the beginning of a low phase.

The `sclIn` input is taken as already synchronous to `clk`.

Top module: `scl_timing_gen`

## Requirements
- R1: `clkCtrl[2:0]` selects the prescale value c (0 to 7), and `clkCtrl[8:3]` holds the coarse divider g (0 to 63). One internal tick occurs every c+1 clock cycles, counted from the start of each phase.
- R2: While c is unchanged, the prescaler count never exceeds c.
- R3: A period lasts P = 20 + 8·g + r ticks, where r is `roundTicks`. The high phase is H = floor(P/2) ticks and the low phase is L = P − H ticks.
- R4: A low phase holds `sclOut` at 0 for exactly L·(c+1) clock cycles.
- R5: After a low phase the block releases `sclOut` to 1. The high count starts on the edge after `sclIn` is first sampled high, so without stretching the line stays high for 1 + H·(c+1) cycles.
- R6: If an outside device holds `sclIn` low for E extra cycles after the release, the low level of the line lengthens by E cycles and the following high level is unchanged.
- R7: `lowStrobe` is 1 only in the first cycle of each low phase. `highStrobe` is 1 only in the first cycle of high counting. The two are never 1 together.
- R8: With `masterEn` at 0, the block goes idle on the next edge, with `sclOut` at 1 and no strobes. `startReq` has no effect while disabled.
- R9: `startReq` with `masterEn` at 1 begins a new low phase on the next edge, whatever phase the block is in.
- R10: The phase counter never increases except when a phase is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| masterEn | input | 1 | Enables the generator |
| startReq | input | 1 | Start condition; restarts the period |
| clkCtrl | input | 9 | Clock control: [2:0] prescale, [8:3] coarse divider |
| roundTicks | input | 6 | Rounding term in ticks |
| sclIn | input | 1 | Sampled SCL line level |
| sclOut | output | 1 | 0 drives SCL low, 1 releases it |
| lowStrobe | output | 1 | First cycle of a low phase |
| highStrobe | output | 1 | First cycle of high counting |

## Verification
On every cycle, the assertions check these properties:
- the prescaler stays within its bound;
- the phase counter only counts down between loads;
- the strobes never overlap, and each one matches its line level;
- the block waits while the line is held low;
- disabling forces idle.

The scenarios must show the exact phase lengths for several prescale, divider and rounding settings. They must also show that a stretch lengthens only the low level, that a restart taken from the high phase gives a full low phase, and that `startReq` is ignored while the master is disabled.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  typedef struct packed {
    logic run;
    logic loadLow;
    logic loadHigh;
  } ctlStrobes_t;
endpackage

// File: rtl/scl_timing_datapath.sv
module scl_timing_datapath
  import scl_timing_pkg::*;
#(
  parameter int CDF_W      = 3,
  parameter int SCGD_W     = 6,
  parameter int ROUND_W    = 6,
  parameter int BASE_TICKS = 20,
  parameter int SCGD_STEP  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctlStrobes_t        ctl,
  input  logic [CDF_W-1:0]   cdfSel,
  input  logic [SCGD_W-1:0]  scgdSel,
  input  logic [ROUND_W-1:0] roundTicks,
  output logic               tick,
  output logic               lastTick
);
  localparam int MAX_TICKS = BASE_TICKS + SCGD_STEP * ((2 ** SCGD_W) - 1) + (2 ** ROUND_W) - 1;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [CDF_W-1:0] preCnt;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] periodTicks;
  logic [CNT_W-1:0] highTicks;
  logic [CNT_W-1:0] lowTicks;
  logic             phaseLoad;

  always_comb begin
    periodTicks = CNT_W'(BASE_TICKS) + CNT_W'(SCGD_STEP) * CNT_W'(scgdSel) + CNT_W'(roundTicks);
    highTicks   = periodTicks >> 1;
    lowTicks    = periodTicks - highTicks;
  end

  assign phaseLoad = ctl.loadLow | ctl.loadHigh;
  assign tick      = ctl.run && (preCnt >= cdfSel);
  assign lastTick  = tick && (phaseCnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt <= '0;
    end else if (phaseLoad || !ctl.run || tick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + CDF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseCnt <= '0;
    end else if (ctl.loadLow) begin
      phaseCnt <= lowTicks;
    end else if (ctl.loadHigh) begin
      phaseCnt <= highTicks;
    end else if (tick && (phaseCnt != '0)) begin
      phaseCnt <= phaseCnt - CNT_W'(1);
    end
  end

  assert_prescale_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(cdfSel) && ($past(preCnt) <= $past(cdfSel))) |-> (preCnt <= cdfSel));

  assert_prescale_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.run |=> (preCnt == '0));

  assert_count_down_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !phaseLoad |=> (phaseCnt <= $past(phaseCnt)));
endmodule

// File: rtl/scl_timing_ctrl.sv
module scl_timing_ctrl
  import scl_timing_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        masterEn,
  input  logic        startReq,
  input  logic        sclIn,
  input  logic        lastTick,
  output ctlStrobes_t ctl,
  output logic        sclOut,
  output logic        lowStrobe,
  output logic        highStrobe
);
  phase_e phase, phaseNext;

  always_comb begin
    ctl          = '0;
    phaseNext    = phase;
    ctl.run      = masterEn && (phase != PH_IDLE);
    if (!masterEn) begin
      phaseNext = PH_IDLE;
    end else if (startReq) begin
      phaseNext   = PH_LOW;
      ctl.loadLow = 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: phaseNext = PH_IDLE;
        PH_LOW:  if (lastTick) phaseNext = PH_WAIT;
        PH_WAIT: if (sclIn) begin
          phaseNext    = PH_HIGH;
          ctl.loadHigh = 1'b1;
        end
        PH_HIGH: if (lastTick) begin
          phaseNext   = PH_LOW;
          ctl.loadLow = 1'b1;
        end
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      lowStrobe  <= 1'b0;
      highStrobe <= 1'b0;
    end else begin
      phase      <= phaseNext;
      lowStrobe  <= ctl.loadLow;
      highStrobe <= ctl.loadHigh;
    end
  end

  assign sclOut = (phase != PH_LOW);

  assert_disable_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !masterEn |=> (sclOut && !lowStrobe && !highStrobe));

  assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(lowStrobe && highStrobe));

  assert_low_strobe_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lowStrobe |-> !sclOut);

  assert_stretch_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT && masterEn && !startReq && !sclIn) |=> (phase == PH_WAIT && !highStrobe));

  assert_restart_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (masterEn && startReq) |=> (!sclOut && lowStrobe));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int CDF_W      = 3,
  parameter int SCGD_W     = 6,
  parameter int ROUND_W    = 6,
  parameter int BASE_TICKS = 20,
  parameter int SCGD_STEP  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      masterEn,
  input  logic                      startReq,
  input  logic [CDF_W+SCGD_W-1:0]   clkCtrl,
  input  logic [ROUND_W-1:0]        roundTicks,
  input  logic                      sclIn,
  output logic                      sclOut,
  output logic                      lowStrobe,
  output logic                      highStrobe
);
  ctlStrobes_t ctl;
  logic        tick;
  logic        lastTick;

  scl_timing_datapath #(
    .CDF_W(CDF_W), .SCGD_W(SCGD_W), .ROUND_W(ROUND_W),
    .BASE_TICKS(BASE_TICKS), .SCGD_STEP(SCGD_STEP)
  ) uDatapath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .cdfSel(clkCtrl[CDF_W-1:0]),
    .scgdSel(clkCtrl[CDF_W+SCGD_W-1:CDF_W]),
    .roundTicks(roundTicks),
    .tick(tick), .lastTick(lastTick)
  );

  scl_timing_ctrl uCtrl (
    .clk(clk), .rst_n(rst_n), .masterEn(masterEn), .startReq(startReq),
    .sclIn(sclIn), .lastTick(lastTick), .ctl(ctl),
    .sclOut(sclOut), .lowStrobe(lowStrobe), .highStrobe(highStrobe)
  );
endmodule

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       masterEn = 1'b0;
  logic       startReq = 1'b0;
  logic [8:0] clkCtrl = '0;
  logic [5:0] roundTicks = '0;
  logic       sclIn;
  logic       sclOut, lowStrobe, highStrobe;
  logic       holdLow = 1'b0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  int expLevel[$];
  int expLen[$];
  bit sync = 0;
  bit armSync = 0;
  bit stretchReq = 0;
  int stretchE = 0;
  int relCnt = 0;

  always #10 clk = ~clk;

  assign sclIn = sclOut & ~holdLow;

  scl_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .masterEn(masterEn), .startReq(startReq),
    .clkCtrl(clkCtrl), .roundTicks(roundTicks), .sclIn(sclIn),
    .sclOut(sclOut), .lowStrobe(lowStrobe), .highStrobe(highStrobe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R6 stretcher: an outside device holding the line low
  always @(posedge clk) begin
    #2;
    if (stretchReq && !holdLow && !sclOut) begin
      holdLow = 1'b1;
      relCnt = 0;
    end else if (holdLow && sclOut) begin
      relCnt++;
      if (relCnt == stretchE + 1) begin
        holdLow = 1'b0;
        stretchReq = 0;
      end
    end
  end

  // Monitor: measures line run lengths and compares them with the scoreboard
  bit prevLine = 1'b1;
  int runLen = 0;
  always @(negedge clk) begin
    if (sclIn == prevLine) begin
      runLen++;
    end else begin
      if (sync && expLen.size() > 0) begin
        int lv, ln;
        lv = expLevel.pop_front();
        ln = expLen.pop_front();
        check(lv == int'(prevLine), "R4/R5/R6 level", int'(prevLine), lv);
        check(ln == runLen, "R1/R2/R3/R4/R5/R6 run length", runLen, ln);
      end
      if (!sclIn && armSync) begin
        sync = 1;
        armSync = 0;
      end
      if (sync && !sclIn) check(lowStrobe == 1'b1, "R7 lowStrobe at low start", int'(lowStrobe), 1);
      runLen = 1;
      prevLine = sclIn;
    end
    if (sync && sclIn && runLen == 2) check(highStrobe == 1'b1, "R7 highStrobe", int'(highStrobe), 1);
    if (sync) check(!(lowStrobe && highStrobe), "R7 exclusive", int'(lowStrobe), 0);
  end

  task automatic runPeriods(input int c, input int g, input int r, input int n, input int e);
    int p, h, l;
    @(negedge clk);
    masterEn = 0; startReq = 0; sync = 0; armSync = 0;
    expLevel.delete(); expLen.delete();
    clkCtrl = {6'(g), 3'(c)};
    roundTicks = 6'(r);
    p = 20 + 8 * g + r;
    h = p / 2;
    l = p - h;
    for (int i = 0; i < n; i++) begin
      expLevel.push_back(0); expLen.push_back(l * (c + 1) + ((i == 0) ? e : 0));
      expLevel.push_back(1); expLen.push_back(1 + h * (c + 1));
    end
    stretchE = e;
    stretchReq = (e > 0);
    @(negedge clk);
    masterEn = 1; startReq = 1; armSync = 1;
    @(negedge clk);
    startReq = 0;
    while (expLen.size() > 0) @(negedge clk);
    masterEn = 0; sync = 0;
    @(negedge clk);
    check(sclOut == 1'b1, "R8 idle after disable", int'(sclOut), 1);
  endtask

  initial begin
    int cnt;
    bit sawStrobe;
    repeat (3) @(negedge clk);
    check(sclOut == 1'b1, "reset sclOut", int'(sclOut), 1);
    check(!lowStrobe && !highStrobe, "reset strobes", int'(lowStrobe | highStrobe), 0);
    rst_n = 1;
    @(negedge clk);

    runPeriods(0, 0, 3, 3, 0);   // R3: P=23 L=12 H=11
    runPeriods(2, 1, 5, 3, 0);   // R1: tick every 3 clocks
    runPeriods(7, 2, 0, 2, 0);   // R1: largest prescale
    runPeriods(1, 0, 2, 2, 7);   // R6: stretched first low

    // R8: start ignored while disabled
    @(negedge clk);
    masterEn = 0; clkCtrl = {6'd0, 3'd0}; roundTicks = 6'd3;
    sawStrobe = 0;
    for (int i = 0; i < 20; i++) begin
      startReq = 1;
      @(negedge clk);
      if (!sclOut || lowStrobe || highStrobe) sawStrobe = 1;
    end
    startReq = 0;
    check(!sawStrobe, "R8 start ignored while disabled", int'(sawStrobe), 0);

    // R9: restart from the high phase
    masterEn = 1; startReq = 1;
    @(negedge clk);
    startReq = 0;
    while (!sclOut) @(negedge clk);
    repeat (5) @(negedge clk);
    check(sclOut == 1'b1, "R9 in high phase before restart", int'(sclOut), 1);
    startReq = 1;
    @(negedge clk);
    startReq = 0;
    check(sclOut == 1'b0, "R9 restart drives low", int'(sclOut), 0);
    check(lowStrobe == 1'b1, "R9 restart lowStrobe", int'(lowStrobe), 1);
    cnt = 1;
    @(negedge clk);
    while (!sclOut) begin cnt++; @(negedge clk); end
    check(cnt == 12, "R9 full low after restart", cnt, 12);
    masterEn = 0;
    @(negedge clk);
    check(sclOut == 1'b1, "R8 disable mid period", int'(sclOut), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule